// File: doc/BRIEF.md
# Quad-Interleaved Scalar Shading Datapath

This block executes one scalar instruction per clock on all four pixels of a 2x2 quad. Each pixel owns a lane. Each lane has its own bank of scalar registers and its own integer ALU. All four lanes run the same opcode with the same register indices in the same cycle. A vector operation is expressed as up to four scalar instructions, one per component (x, y, z, w), issued on consecutive cycles. Swizzles and component write masks are resolved earlier by register renaming, so the datapath only sees plain scalar register numbers.

Results return to the banks exactly four cycles after issue. Consecutive component instructions are independent, so an ALU latency of up to four cycles is hidden without forwarding paths or stall logic. A load port fills one register index in all four banks at once. A read-out port shows one register index from all four banks.

Top module: `quad_scalar_datapath`

## Requirements
- R1: An asynchronous active-low reset discards every instruction still in flight, and none of them later writes a bank.
- R2: All four lanes apply the same opcode and register indices in the same cycle, each to the values held in its own bank.
- R3: Opcode encoding, with all arithmetic modulo 2^32: 0 MOV (a), 1 ADD (a+b), 2 SUB (a-b), 3 MUL (low 32 bits of a*b), 4 MAD (low 32 bits of a*b+d), 5 MIN (signed), 6 MAX (signed), 7 no operation.
- R4: An instruction accepted in cycle t writes its result at the end of cycle t+3. An instruction issued in cycle t+4 or later reads that result, and the read-out port shows it from cycle t+4.
- R5: There is no forwarding. An instruction issued in cycle t+1, t+2 or t+3 reads the value the destination held before the instruction of cycle t.
- R6: MAD takes its addend d from the destination register, read when the MAD is issued.
- R7: Bit i of iss_lanes enables the write of lane i. A lane whose bit is 0 keeps its old register value.
- R8: When iss_valid is 0, or the opcode is 7, nothing is written to any bank.
- R9: A load writes ld_data into register ld_addr of every bank at the end of its cycle. Loads may only be presented while no write-back is pending.
- R10: rd_data shows register rd_addr of all banks combinationally. Lane i occupies bits 32i+31 down to 32i, and ld_data uses the same layout.
- R11: A new instruction can issue every cycle with no stall, so a 1-, 2-, 3- or 4-component operation on a quad occupies 1, 2, 3 or 4 issue cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction present this cycle |
| iss_op | input | 3 | Opcode |
| iss_dst | input | 5 | Destination register, also the MAD addend |
| iss_srca | input | 5 | First source register |
| iss_srcb | input | 5 | Second source register |
| iss_lanes | input | 4 | Per-pixel write enable |
| ld_valid | input | 1 | Load request |
| ld_addr | input | 5 | Register index to load |
| ld_data | input | 128 | Four lane values, lane 0 in the low bits |
| rd_addr | input | 5 | Register index to show |
| rd_data | output | 128 | Four lane values of register rd_addr |

## Verification
The assertions assume that the load port is used only while no write-back is pending, because a bank has a single write port. They also assume that the issue inputs are driven to known values throughout reset. The stimulus respects both. Every load happens after at least three idle issue cycles, and the random phase issues instructions only. All inputs are held at zero while reset is asserted.

// File: rtl/quad_scalar_datapath.sv
module quad_scalar_datapath #(
  parameter int LANES = 4,
  parameter int NREG  = 32,
  parameter int W     = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [2:0]              iss_op,
  input  logic [$clog2(NREG)-1:0] iss_dst,
  input  logic [$clog2(NREG)-1:0] iss_srca,
  input  logic [$clog2(NREG)-1:0] iss_srcb,
  input  logic [LANES-1:0]        iss_lanes,
  input  logic                    ld_valid,
  input  logic [$clog2(NREG)-1:0] ld_addr,
  input  logic [LANES*W-1:0]      ld_data,
  input  logic [$clog2(NREG)-1:0] rd_addr,
  output logic [LANES*W-1:0]      rd_data
);
  localparam int RW  = $clog2(NREG);
  localparam int STG = 3;
  localparam logic [2:0] OP_MOV = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_MUL = 3'd3,
                         OP_MAD = 3'd4, OP_MIN = 3'd5, OP_MAX = 3'd6, OP_NOP = 3'd7;

  logic [LANES*W-1:0] alu_res;
  logic [STG-1:0]     p_vld;
  logic [RW-1:0]      p_dst [STG];
  logic [LANES-1:0]   p_msk [STG];
  logic [LANES*W-1:0] p_dat [STG];

  wire                iss_wr = iss_valid && (iss_op != OP_NOP) && (|iss_lanes);
  wire                wb_vld = p_vld[STG-1];
  wire [RW-1:0]       wb_dst = p_dst[STG-1];
  wire [LANES-1:0]    wb_msk = p_msk[STG-1];
  wire [LANES*W-1:0]  wb_dat = p_dat[STG-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) p_vld <= '0;
    else        p_vld <= {p_vld[STG-2:0], iss_wr};

  always_ff @(posedge clk) begin
    p_dst[0] <= iss_dst;
    p_msk[0] <= iss_lanes;
    p_dat[0] <= alu_res;
    for (int k = 1; k < STG; k++) begin
      p_dst[k] <= p_dst[k-1];
      p_msk[k] <= p_msk[k-1];
      p_dat[k] <= p_dat[k-1];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [W-1:0] bank [NREG];
    logic [W-1:0] opa, opb, acc, res;

    assign opa = bank[iss_srca];
    assign opb = bank[iss_srcb];
    assign acc = bank[iss_dst];

    always_comb begin
      case (iss_op)
        OP_ADD:  res = opa + opb;
        OP_SUB:  res = opa - opb;
        OP_MUL:  res = opa * opb;
        OP_MAD:  res = opa * opb + acc;
        OP_MIN:  res = ($signed(opa) < $signed(opb)) ? opa : opb;
        OP_MAX:  res = ($signed(opa) > $signed(opb)) ? opa : opb;
        default: res = opa;
      endcase
    end

    assign alu_res[l*W +: W] = res;
    assign rd_data[l*W +: W] = bank[rd_addr];

    always_ff @(posedge clk)
      if (wb_vld && wb_msk[l]) bank[wb_dst]  <= wb_dat[l*W +: W];
      else if (ld_valid)       bank[ld_addr] <= ld_data[l*W +: W];
  end

  AST_WB_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_wr |-> ##3 wb_vld) else $error("write-back missing"); // R4
  AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> ##3 !wb_vld) else $error("spurious write-back"); // R8
  AST_WB_DST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wb_vld |-> wb_dst == $past(iss_dst, 3)) else $error("destination skew"); // R4
  AST_WB_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    wb_vld |-> (wb_msk & ~$past(iss_lanes, 3)) == '0) else $error("lane mask widened"); // R7
  AST_LOAD_PORT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !wb_vld) else $error("load collides with write-back"); // R9
endmodule

// File: tb/quad_scalar_datapath_bench.sv
module quad_scalar_datapath_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         iss_valid = 1'b0;
  logic [2:0]   iss_op = '0;
  logic [4:0]   iss_dst = '0, iss_srca = '0, iss_srcb = '0;
  logic [3:0]   iss_lanes = '0;
  logic         ld_valid = 1'b0;
  logic [4:0]   ld_addr = '0;
  logic [127:0] ld_data = '0;
  logic [4:0]   rd_addr = '0;
  logic [127:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0]  m_rf [4][32];
  logic         mp_vld [3];
  logic [4:0]   mp_dst [3];
  logic [3:0]   mp_msk [3];
  logic [127:0] mp_dat [3];

  always #10 clk = ~clk;

  quad_scalar_datapath u_quad_scalar_datapath (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_srca(iss_srca), .iss_srcb(iss_srcb), .iss_lanes(iss_lanes),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] a, b, d);
    case (op)
      3'd1: return a + b;
      3'd2: return a - b;
      3'd3: return a * b;
      3'd4: return a * b + d;
      3'd5: return ($signed(a) < $signed(b)) ? a : b;
      3'd6: return ($signed(a) > $signed(b)) ? a : b;
      default: return a;
    endcase
  endfunction

  function automatic logic [127:0] pk(input logic [31:0] a0, a1, a2, a3);
    return {a3, a2, a1, a0};
  endfunction

  function automatic logic [127:0] mrow(input logic [4:0] r);
    return {m_rf[3][r], m_rf[2][r], m_rf[1][r], m_rf[0][r]};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [2:0] op, input logic [4:0] d, a, b,
                       input logic [3:0] ln, input logic lv, input logic [4:0] la,
                       input logic [127:0] ldat);
    logic [127:0] res;
    iss_valid = v; iss_op = op; iss_dst = d; iss_srca = a; iss_srcb = b; iss_lanes = ln;
    ld_valid = lv; ld_addr = la; ld_data = ldat;
    for (int l = 0; l < 4; l++) res[l*32 +: 32] = ref_alu(op, m_rf[l][a], m_rf[l][b], m_rf[l][d]);
    @(posedge clk);
    for (int l = 0; l < 4; l++)
      if (mp_vld[2] && mp_msk[2][l]) m_rf[l][mp_dst[2]] = mp_dat[2][l*32 +: 32];
      else if (lv) m_rf[l][la] = ldat[l*32 +: 32];
    for (int k = 2; k > 0; k--) begin
      mp_vld[k] = mp_vld[k-1]; mp_dst[k] = mp_dst[k-1];
      mp_msk[k] = mp_msk[k-1]; mp_dat[k] = mp_dat[k-1];
    end
    mp_vld[0] = v && (op != 3'd7) && (ln != 4'd0) && rst_n;
    mp_dst[0] = d; mp_msk[0] = ln; mp_dat[0] = res;
    @(negedge clk);
    iss_valid = 0; ld_valid = 0;
    rd_addr = 5'($urandom % 32);
    #1 check("R10 read-out vs model", rd_data, mrow(rd_addr));
  endtask

  task automatic issue(input logic [2:0] op, input logic [4:0] d, a, b, input logic [3:0] ln);
    cycle(1'b1, op, d, a, b, ln, 1'b0, 5'd0, 128'd0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 3'd0, 5'd0, 5'd0, 5'd0, 4'd0, 1'b0, 5'd0, 128'd0);
  endtask
  task automatic load(input logic [4:0] r, input logic [127:0] v);
    cycle(1'b0, 3'd0, 5'd0, 5'd0, 5'd0, 4'd0, 1'b1, r, v);
  endtask
  task automatic peek(input logic [4:0] r, input logic [127:0] exp, input string req);
    rd_addr = r;
    #1 check(req, rd_data, exp);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    for (int k = 0; k < 3; k++) mp_vld[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    for (int r = 0; r < 32; r++) load(5'(r), {$urandom, $urandom, $urandom, $urandom});
    idle(1);
    for (int r = 0; r < 32; r++) peek(5'(r), mrow(5'(r)), "R9 load of all lanes");

    // R1: reset discards an in-flight write
    load(5'd5, pk(1, 2, 3, 4));
    idle(3);
    issue(3'd0, 5'd5, 5'd0, 5'd0, 4'hF);
    rst_n = 0;
    for (int k = 0; k < 3; k++) mp_vld[k] = 0;
    idle(2);
    rst_n = 1;
    idle(4);
    peek(5'd5, pk(1, 2, 3, 4), "R1 in-flight write dropped by reset");

    load(5'd1, pk(10, 20, 30, 40));
    load(5'd2, pk(0, 0, 0, 0));
    idle(3);
    // R4/R5: dependent instructions at distance 3 and 4
    issue(3'd1, 5'd2, 5'd1, 5'd1, 4'hF);
    idle(2);
    issue(3'd0, 5'd3, 5'd2, 5'd0, 4'hF);
    peek(5'd2, pk(20, 40, 60, 80), "R4 visible on read-out at t+4");
    issue(3'd0, 5'd4, 5'd2, 5'd0, 4'hF);
    idle(4);
    peek(5'd3, pk(0, 0, 0, 0), "R5 distance 3 reads old value");
    peek(5'd4, pk(20, 40, 60, 80), "R4 distance 4 reads new value");

    // R6: MAD addend from destination
    load(5'd6, pk(5, 5, 5, 5));
    issue(3'd4, 5'd6, 5'd1, 5'd1, 4'hF);
    idle(4);
    peek(5'd6, pk(105, 405, 905, 1605), "R6 MAD accumulate");

    // R7: lane mask
    load(5'd7, pk(9, 9, 9, 9));
    issue(3'd0, 5'd7, 5'd1, 5'd0, 4'b0101);
    idle(4);
    peek(5'd7, pk(10, 9, 30, 9), "R7 masked lanes keep value");

    // R8: no write without valid, none for opcode 7
    cycle(1'b0, 3'd1, 5'd7, 5'd1, 5'd1, 4'hF, 1'b0, 5'd0, 128'd0);
    issue(3'd7, 5'd7, 5'd1, 5'd1, 4'hF);
    idle(4);
    peek(5'd7, pk(10, 9, 30, 9), "R8 invalid and no-op leave bank");

    // R3: signed MIN/MAX, SUB, MUL low half
    load(5'd8, pk(-1, 5, -7, 0));
    load(5'd9, pk(1, -5, 3, 0));
    load(5'd13, pk(32'h10000, 32'h10000, 32'h10003, 32'h7));
    issue(3'd5, 5'd10, 5'd8, 5'd9, 4'hF);
    issue(3'd6, 5'd11, 5'd8, 5'd9, 4'hF);
    issue(3'd2, 5'd12, 5'd8, 5'd9, 4'hF);
    issue(3'd3, 5'd14, 5'd13, 5'd13, 4'hF);
    idle(4);
    peek(5'd10, pk(-1, -5, -7, 0), "R3 MIN signed");
    peek(5'd11, pk(1, 5, 3, 0), "R3 MAX signed");
    peek(5'd12, pk(-2, 10, -10, 0), "R3 SUB");
    peek(5'd14, pk(0, 0, 32'h60009, 49), "R3 MUL low 32 bits");

    // R11: four-component add issued on four consecutive cycles
    for (int c = 0; c < 4; c++) load(5'(16 + c), pk(c + 1, c + 1, c + 1, c + 1));
    for (int c = 0; c < 4; c++) issue(3'd1, 5'(20 + c), 5'(16 + c), 5'd1, 4'hF);
    idle(4);
    for (int c = 0; c < 4; c++)
      peek(5'(20 + c), pk(c + 11, c + 21, c + 31, c + 41), "R11 back-to-back vector components");

    // R2/R3: random instruction stream, checked every cycle against the model
    for (int i = 0; i < 3000; i++)
      cycle(($urandom % 4) != 0, 3'($urandom % 8), 5'($urandom % 32), 5'($urandom % 32),
            5'($urandom % 32), 4'($urandom % 16), 1'b0, 5'd0, 128'd0);
    idle(4);
    for (int r = 0; r < 32; r++) peek(5'(r), mrow(5'(r)), "R2 per-lane bank contents after random run");

    done = 1;
    summary();
  end
endmodule